// File: doc/BRIEF.md
# Fractional Rate Resampling Controller

This block produces the per-output control for a sample-rate converter. A programmable ratio sets the spacing of output samples measured in input samples. The ratio is the input rate divided by the output rate, so it equals the output sample spacing divided by the input sample spacing. It is an unsigned fixed-point word with 2 integer bits and 30 fraction bits, and it must lie from 1.0 up to, but not including, 4.0.

Each time the consumer asks for an output sample, the ratio is added to a fractional phase held in a 32-bit accumulator. The integer part of the sum is reported as the number of fresh input samples the filter must shift in before it computes this output. The upper bits of the fraction are reported as a 12-bit delay word that selects the interpolation coefficient set. After each step only the fraction is kept. A synchronous clear input zeroes the phase so that several controllers restart in phase. A new ratio only takes effect between steps.

Top module: `frac_resamp_ctrl`

## Requirements
- R1: After reset, out_vld, adv_cnt and delay_word are 0, the phase is 0 and the active ratio is 1.0 (0x4000_0000). The first step after reset therefore reports adv_cnt=1 and delay_word=0.
- R2: A write on ratio_wr whose two top bits (31:30, the integer part) are nonzero replaces the active ratio. A write whose integer part is 00 is ignored, and the active ratio keeps its value.
- R3: A step request (step_req high, sync_clr low) at a clock edge makes out_vld high for exactly the following cycle. With it, adv_cnt shows the integer part of phase + ratio, which always lies in the range 1 to 4.
- R4: With each step result, delay_word equals bits 29:18 of phase + ratio, which are the top 12 bits of the 30-bit fraction of the sum.
- R5: After a step the phase holds only the 30-bit fraction of phase + ratio. The integer part is dropped once it has been reported.
- R6: A ratio write in the same cycle as a step does not affect that step. The new ratio applies from the next step on.
- R7: sync_clr zeroes the phase and suppresses any step requested in the same cycle, so out_vld is low in the following cycle. The active ratio is kept.
- R8: In cycles without a step, out_vld is low, adv_cnt and delay_word hold their values, and the phase is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_clr | input | 1 | Synchronous phase clear; overrides a step |
| ratio_wr | input | 1 | Ratio write strobe |
| ratio_wdata | input | 32 | New ratio, 2.30 unsigned fixed point |
| step_req | input | 1 | Request one output sample step |
| out_vld | output | 1 | Step result valid, one cycle per step |
| adv_cnt | output | 3 | Input samples to advance for this output (1 to 4) |
| delay_word | output | 12 | Fractional delay for coefficient selection |

## Verification
The hardest result to reach is an advance count of 4. It needs a phase fraction close to 1.0 followed by a ratio close to 4.0. The stimulus reaches it by programming the largest legal ratio, 0xFFFF_FFFF, and stepping twice from a cleared phase. The first step leaves the fraction at 0x3FFF_FFFF, and the second step carries into 4. A ratio write that coincides with a step is also driven on purpose, and the next two steps are checked to tell the old ratio apart from the new one.

// File: rtl/frac_resamp_pkg.sv
package frac_resamp_pkg;
   // Default geometry of the rate word and the reported fields
   localparam int DEF_INT_W  = 2;
   localparam int DEF_FRAC_W = 30;
   localparam int DEF_DLY_W  = 12;

   // A ratio is legal when its integer field is nonzero (1.0 <= r < 4.0)
   function automatic bit ratio_legal(input logic [DEF_INT_W-1:0] int_part);
      return int_part != '0;
   endfunction
endpackage

// File: rtl/frac_resamp_ratio_reg.sv
module frac_resamp_ratio_reg #(
   parameter int INT_W  = 2,
   parameter int FRAC_W = 30,
   localparam int RW    = INT_W + FRAC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [RW-1:0] wr_data,
   output logic [RW-1:0] ratio_q
);
   localparam logic [RW-1:0] ONE = RW'(1) << FRAC_W;

   logic legal;

   generate
      if (INT_W == frac_resamp_pkg::DEF_INT_W) begin : g_pkg_check
         assign legal = frac_resamp_pkg::ratio_legal(wr_data[RW-1 -: INT_W]);
      end else begin : g_gen_check
         assign legal = |wr_data[RW-1 -: INT_W];
      end
   endgenerate

   // Register update: a write lands after the current edge, so a step
   // sampled at the same edge still sees the previous value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ratio_q <= ONE;
      else if (wr_en && legal)
         ratio_q <= wr_data;
   end
endmodule

// File: rtl/frac_resamp_phase_acc.sv
module frac_resamp_phase_acc #(
   parameter int INT_W  = 2,
   parameter int FRAC_W = 30,
   parameter int DLY_W  = 12,
   localparam int RW    = INT_W + FRAC_W,
   localparam int ADV_W = INT_W + 1,
   localparam int SUM_W = FRAC_W + ADV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [RW-1:0]    ratio,
   output logic             res_vld,
   output logic [ADV_W-1:0] res_adv,
   output logic [DLY_W-1:0] res_dly
);
   logic [FRAC_W-1:0] phase_q;
   logic [SUM_W-1:0]  sum;
   logic [DLY_W-1:0]  dly_next;

   // phase fraction (< 1.0) plus ratio (< 4.0) is below 5.0: ADV_W bits suffice
   assign sum = SUM_W'(phase_q) + SUM_W'(ratio);

   generate
      if (DLY_W == FRAC_W) begin : g_dly_full
         assign dly_next = sum[FRAC_W-1:0];
      end else begin : g_dly_top
         assign dly_next = sum[FRAC_W-1 -: DLY_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         res_vld <= 1'b0;
         res_adv <= '0;
         res_dly <= '0;
      end else if (clr) begin
         phase_q <= '0;
         res_vld <= 1'b0;
      end else if (step) begin
         phase_q <= sum[FRAC_W-1:0];
         res_vld <= 1'b1;
         res_adv <= sum[SUM_W-1 -: ADV_W];
         res_dly <= dly_next;
      end else begin
         res_vld <= 1'b0;
      end
   end
endmodule

// File: rtl/frac_resamp_ctrl.sv
module frac_resamp_ctrl #(
   parameter int INT_W  = frac_resamp_pkg::DEF_INT_W,
   parameter int FRAC_W = frac_resamp_pkg::DEF_FRAC_W,
   parameter int DLY_W  = frac_resamp_pkg::DEF_DLY_W,
   localparam int RW    = INT_W + FRAC_W,
   localparam int ADV_W = INT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_clr,
   input  logic             ratio_wr,
   input  logic [RW-1:0]    ratio_wdata,
   input  logic             step_req,
   output logic             out_vld,
   output logic [ADV_W-1:0] adv_cnt,
   output logic [DLY_W-1:0] delay_word
);
   // Elaboration-time parameter checks
   generate
      if (INT_W < 1) begin : g_bad_int
         $error("INT_W must be at least 1");
      end
      if (DLY_W < 1 || DLY_W > FRAC_W) begin : g_bad_dly
         $error("DLY_W must lie in 1..FRAC_W");
      end
   endgenerate

   logic [RW-1:0] ratio_act;

   frac_resamp_ratio_reg #(
      .INT_W (INT_W),
      .FRAC_W(FRAC_W)
   ) u_ratio (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ratio_wr),
      .wr_data(ratio_wdata),
      .ratio_q(ratio_act)
   );

   frac_resamp_phase_acc #(
      .INT_W (INT_W),
      .FRAC_W(FRAC_W),
      .DLY_W (DLY_W)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sync_clr),
      .step   (step_req),
      .ratio  (ratio_act),
      .res_vld(out_vld),
      .res_adv(adv_cnt),
      .res_dly(delay_word)
   );
endmodule

// File: rtl/frac_resamp_ctrl_chk.sv
module frac_resamp_ctrl_chk #(
   parameter int RW    = 32,
   parameter int ADV_W = 3,
   parameter int DLY_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_clr,
   input logic             ratio_wr,
   input logic [RW-1:0]    ratio_wdata,
   input logic             step_req,
   input logic             out_vld,
   input logic [ADV_W-1:0] adv_cnt,
   input logic [DLY_W-1:0] delay_word,
   input logic [RW-1:0]    ratio_act
);
   assert_vld_from_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(step_req && !sync_clr));

   assert_adv_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (adv_cnt >= ADV_W'(1) && adv_cnt <= ADV_W'(4)));

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> ($stable(adv_cnt) && $stable(delay_word)));

   assert_ignore_bad_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_wr && ratio_wdata[RW-1 -: 2] == 2'b00) |=> $stable(ratio_act));

   assert_clear_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_clr |=> !out_vld);

   assert_ratio_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_act[RW-1 -: 2] != 2'b00);
endmodule

bind frac_resamp_ctrl frac_resamp_ctrl_chk #(
   .RW   (RW),
   .ADV_W(ADV_W),
   .DLY_W(DLY_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_clr   (sync_clr),
   .ratio_wr   (ratio_wr),
   .ratio_wdata(ratio_wdata),
   .step_req   (step_req),
   .out_vld    (out_vld),
   .adv_cnt    (adv_cnt),
   .delay_word (delay_word),
   .ratio_act  (ratio_act)
);

// File: tb/frac_resamp_ctrl_bench.sv
module frac_resamp_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_clr = 1'b0;
   logic        ratio_wr = 1'b0;
   logic [31:0] ratio_wdata = '0;
   logic        step_req = 1'b0;
   logic        out_vld;
   logic [2:0]  adv_cnt;
   logic [11:0] delay_word;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   frac_resamp_ctrl u_frac_resamp_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_clr   (sync_clr),
      .ratio_wr   (ratio_wr),
      .ratio_wdata(ratio_wdata),
      .step_req   (step_req),
      .out_vld    (out_vld),
      .adv_cnt    (adv_cnt),
      .delay_word (delay_word)
   );

   // Vector table: ratio, then expected (adv, delay) for two steps from phase 0
   localparam int NV = 7;
   localparam logic [31:0] V_RATIO [NV] = '{32'h4000_0000, 32'h6000_0000, 32'h8000_0000,
      32'hFFFF_FFFF, 32'h5000_0000, 32'hC000_0000, 32'h4004_0000};
   localparam logic [2:0]  V_ADV1 [NV] = '{3'd1, 3'd1, 3'd2, 3'd3, 3'd1, 3'd3, 3'd1};
   localparam logic [11:0] V_DLY1 [NV] = '{12'h000, 12'h800, 12'h000, 12'hFFF, 12'h400, 12'h000, 12'h001};
   localparam logic [2:0]  V_ADV2 [NV] = '{3'd1, 3'd2, 3'd2, 3'd4, 3'd1, 3'd3, 3'd1};
   localparam logic [11:0] V_DLY2 [NV] = '{12'h000, 12'h000, 12'h000, 12'hFFF, 12'h800, 12'h000, 12'h002};

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic write_ratio(input logic [31:0] r);
      @(negedge clk);
      ratio_wr = 1'b1;
      ratio_wdata = r;
      @(negedge clk);
      ratio_wr = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      sync_clr = 1'b1;
      @(negedge clk);
      sync_clr = 1'b0;
   endtask

   // One step; result registered at the following edge, sampled at the next negedge
   task automatic step_check(input string tag, input logic [2:0] ea, input logic [11:0] ed);
      @(negedge clk);
      step_req = 1'b1;
      @(negedge clk);
      step_req = 1'b0;
      check({tag, " out_vld"}, int'(out_vld), 1);
      check({tag, " adv_cnt"}, int'(adv_cnt), int'(ea));
      check({tag, " delay_word"}, int'(delay_word), int'(ed));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 out_vld in reset", int'(out_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_vld", int'(out_vld), 0);
      check("R1 adv_cnt", int'(adv_cnt), 0);
      check("R1 delay_word", int'(delay_word), 0);
      step_check("R1 first step at ratio 1.0", 3'd1, 12'h000);

      // R3 R4 R5: table walk; second step depends on kept fraction (R5)
      for (int i = 0; i < NV; i++) begin
         write_ratio(V_RATIO[i]);
         pulse_clr();
         step_check("R3 R4 table step1", V_ADV1[i], V_DLY1[i]);
         step_check("R5 table step2", V_ADV2[i], V_DLY2[i]);
      end

      // R3: out_vld lasts one cycle only
      @(negedge clk);
      check("R3 out_vld single cycle", int'(out_vld), 0);

      // R2: integer part 00 is ignored (ratio stays 0x4004_0000)
      pulse_clr();
      write_ratio(32'h2000_0000);
      step_check("R2 ignored write", 3'd1, 12'h001);

      // R6: write coincident with a step; old ratio 2.0 used, then 1.5
      write_ratio(32'h8000_0000);
      pulse_clr();
      @(negedge clk);
      step_req = 1'b1;
      ratio_wr = 1'b1;
      ratio_wdata = 32'h6000_0000;
      @(negedge clk);
      step_req = 1'b0;
      ratio_wr = 1'b0;
      check("R6 step uses old ratio adv", int'(adv_cnt), 2);
      check("R6 step uses old ratio delay", int'(delay_word), 0);
      step_check("R6 next step uses new ratio", 3'd1, 12'h800);

      // R7: clear together with step; phase was 0.5
      @(negedge clk);
      sync_clr = 1'b1;
      step_req = 1'b1;
      @(negedge clk);
      sync_clr = 1'b0;
      step_req = 1'b0;
      check("R7 step suppressed", int'(out_vld), 0);
      step_check("R7 phase restarted, ratio kept", 3'd1, 12'h800);

      // R8: idle cycles leave phase (0.5) and outputs untouched
      repeat (5) @(negedge clk);
      check("R8 idle out_vld", int'(out_vld), 0);
      check("R8 idle adv held", int'(adv_cnt), 1);
      check("R8 idle delay held", int'(delay_word), 12'h800);
      step_check("R8 phase unchanged", 3'd2, 12'h000);

      // R1: reset mid-run returns ratio to 1.0 and phase to 0
      write_ratio(32'hC000_0000);
      step_check("R1 pre-reset step", 3'd3, 12'h000);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears adv", int'(adv_cnt), 0);
      rst_n = 1'b1;
      step_check("R1 ratio back to 1.0", 3'd1, 12'h000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule